// File: doc/BRIEF.md
# Instruction Cache Invalidation Controller

This block holds the control and flush logic for a small instruction cache placed in front of a code-fetch path. Software reaches it through two memory-mapped registers. The control register carries an enable bit and a read-only ready flag. Any write to the flush register throws away the whole cache. The block does not look up hits and does not refill lines. It drives the write strobes and indices that clear the tag array, and it drives a select that tells the fetch path whether to use the cache arrays or the line fill buffer bypass.

The block runs three kinds of sweep, one index per clock. The first is the power-on invalidation, started by reset. The second is a software invalidation, started by a flush write or by clearing the enable bit; it clears the valid bit of every tag entry. The third is a zeroize sweep, started by the rising edge of a request input; it writes zeros into every word of the data array and every entry of the tag array. The ready flag stays low while any sweep runs. While ready is low, or while the cache is disabled, fetches are steered to the bypass path.

Top module: `icache_flush_ctl`

## Requirements
- R1: After reset, enable reads 0 and ready reads 0. A power-on invalidation sweep then clears tag indices 0 to LINES-1. Ready reads 1 after it.
- R2: The control register is at offset 0x100. Bit 0 is enable and can be read and written. Bit 16 is ready and is read-only. Every other bit reads 0, and writes to those bits change nothing.
- R3: Any write of any value to offset 0x700 starts an invalidation sweep. Reads of offset 0x700 return 0, and reads of any unmapped offset return 0.
- R4: A control write with bit 0 equal to 0 starts an invalidation sweep. A control write with bit 0 equal to 1 starts no sweep.
- R5: An invalidation sweep asserts tag_we with tag_wr_zero=0 once per cycle, for indices 0, 1, ... LINES-1 in order, starting in the cycle after the accepting edge. Ready is low for exactly LINES cycles and then rises.
- R6: An invalidation request accepted k cycles into a running invalidation sweep restarts the sweep from index 0. Ready is then low for k+LINES cycles in total.
- R7: A rising edge on zero_req starts a zeroize sweep of max(LINES, DATA_WORDS) cycles. In that sweep, data_we covers data indices 0 to DATA_WORDS-1, and tag_we with tag_wr_zero=1 covers tag indices 0 to LINES-1, with both at the same index in each cycle. Holding zero_req high gives one sweep only. A new rising edge restarts the zeroize sweep from index 0.
- R8: Zeroize takes priority. If a zeroize edge arrives in the same cycle as an invalidation request, only the zeroize runs. An invalidation request during a zeroize sweep is ignored. A zeroize edge during an invalidation sweep replaces it.
- R9: cache_use is 1 exactly when enable is 1 and ready is 1. fetch_bypass is its complement.
- R10: reg_rdata shows the read value one cycle after the edge that samples reg_rd. It reflects the state at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts the power-on invalidation |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, registered |
| zero_req | input | 1 | Zeroize request level; its rising edge starts a zeroize sweep |
| cache_use | output | 1 | Fetches may be served by the cache arrays |
| fetch_bypass | output | 1 | Fetches go to the line fill buffer |
| tag_we | output | 1 | Tag array write strobe |
| tag_wr_zero | output | 1 | 1: write the whole tag entry as zero; 0: clear its valid bit only |
| tag_idx | output | $clog2(LINES) | Tag array index |
| data_we | output | 1 | Data array write-zero strobe |
| data_idx | output | $clog2(DATA_WORDS) | Data array word index |

## Verification
The hardest cases to reach from the ports are requests that collide with a running sweep. These are a restart landing on each index of an invalidation, a zeroize edge in the same cycle as a flush write, and a flush arriving mid-zeroize. The bench uses small arrays so that a loop can place the second request at every offset from one cycle to the end of the sweep. For each offset it predicts the total number of tag writes and of bypass cycles as the offset plus the sweep length. It then compares those totals with counts taken from the tag and bypass outputs.

// File: rtl/icf_pkg.sv
package icf_pkg;

    typedef enum logic [1:0] {
        SW_IDLE  = 2'd0,
        SW_INVAL = 2'd1,
        SW_ZERO  = 2'd2
    } sweep_e;

    localparam logic [11:0] CTRL_OFF  = 12'h100;
    localparam logic [11:0] FLUSH_OFF = 12'h700;
    localparam int          READY_BIT = 16;

endpackage

// File: rtl/icf_regs.sv
module icf_regs
    import icf_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              ready,
    output logic              enable,
    output logic              inval_req,
    output logic [DATA_W-1:0] reg_rdata
);

    typedef struct packed {
        logic              enable;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic hit_ctrl, hit_flush;
    logic unused_wbits;

    assign hit_ctrl     = (reg_addr == ADDR_W'(CTRL_OFF));
    assign hit_flush    = (reg_addr == ADDR_W'(FLUSH_OFF));
    assign unused_wbits = ^reg_wdata[DATA_W-1:1];

    always_comb begin
        r_d       = r_q;
        inval_req = 1'b0;
        if (reg_wr) begin
            if (hit_ctrl) begin
                r_d.enable = reg_wdata[0];
                inval_req  = ~reg_wdata[0];
            end
            if (hit_flush) begin
                inval_req = 1'b1;
            end
        end
        if (reg_rd) begin
            r_d.rdata = '0;
            if (hit_ctrl) begin
                r_d.rdata[0]         = r_q.enable;
                r_d.rdata[READY_BIT] = ready;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign enable    = r_q.enable;
    assign reg_rdata = r_q.rdata;

endmodule

// File: rtl/icf_edge.sv
module icf_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic pulse_out
);

    typedef struct packed {
        logic prev;
    } edge_t;

    edge_t e_d, e_q;

    always_comb begin
        e_d.prev  = level_in;
        pulse_out = level_in & ~e_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

endmodule

// File: rtl/icf_sweep.sv
module icf_sweep
    import icf_pkg::*;
#(
    parameter int LINES      = 512,
    parameter int DATA_WORDS = 4096,
    parameter int TAG_W      = $clog2(LINES),
    parameter int DIDX_W     = $clog2(DATA_WORDS),
    parameter int ZLEN       = (DATA_WORDS > LINES) ? DATA_WORDS : LINES,
    parameter int IDX_W      = $clog2(ZLEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inval_req,
    input  logic              zero_pulse,
    output logic              ready,
    output logic              tag_we,
    output logic              tag_wr_zero,
    output logic [TAG_W-1:0]  tag_idx,
    output logic              data_we,
    output logic [DIDX_W-1:0] data_idx,
    output sweep_e            state,
    output logic [IDX_W-1:0]  idx
);

    localparam logic [IDX_W-1:0] INVAL_LAST = IDX_W'(LINES - 1);
    localparam logic [IDX_W-1:0] ZERO_LAST  = IDX_W'(ZLEN - 1);
    localparam logic [IDX_W:0]   LINES_X    = (IDX_W + 1)'(LINES);
    localparam logic [IDX_W:0]   WORDS_X    = (IDX_W + 1)'(DATA_WORDS);

    typedef struct packed {
        sweep_e           state;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (zero_pulse) begin
            s_d.state = SW_ZERO;
            s_d.idx   = '0;
        end else if (inval_req && s_q.state != SW_ZERO) begin
            s_d.state = SW_INVAL;
            s_d.idx   = '0;
        end else begin
            case (s_q.state)
                SW_INVAL: begin
                    if (s_q.idx == INVAL_LAST) begin
                        s_d.state = SW_IDLE;
                        s_d.idx   = '0;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
                SW_ZERO: begin
                    if (s_q.idx == ZERO_LAST) begin
                        s_d.state = SW_IDLE;
                        s_d.idx   = '0;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
                default: begin
                    s_d.idx = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state <= SW_INVAL;
            s_q.idx   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        ready       = (s_q.state == SW_IDLE);
        tag_wr_zero = (s_q.state == SW_ZERO);
        tag_we      = (s_q.state == SW_INVAL) ||
                      ((s_q.state == SW_ZERO) && ({1'b0, s_q.idx} < LINES_X));
        data_we     = (s_q.state == SW_ZERO) && ({1'b0, s_q.idx} < WORDS_X);
        tag_idx     = s_q.idx[TAG_W-1:0];
        data_idx    = s_q.idx[DIDX_W-1:0];
        state       = s_q.state;
        idx         = s_q.idx;
    end

endmodule

// File: rtl/icache_flush_ctl.sv
module icache_flush_ctl
    import icf_pkg::*;
#(
    parameter int LINES      = 512,
    parameter int DATA_WORDS = 4096,
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int TAG_W      = $clog2(LINES),
    parameter int DIDX_W     = $clog2(DATA_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              zero_req,
    output logic              cache_use,
    output logic              fetch_bypass,
    output logic              tag_we,
    output logic              tag_wr_zero,
    output logic [TAG_W-1:0]  tag_idx,
    output logic              data_we,
    output logic [DIDX_W-1:0] data_idx
);

    localparam int ZLEN  = (DATA_WORDS > LINES) ? DATA_WORDS : LINES;
    localparam int IDX_W = $clog2(ZLEN);

    logic             enable;
    logic             ready;
    logic             inval_req;
    logic             zero_pulse;
    sweep_e           seq_state;
    logic [IDX_W-1:0] seq_idx;

    icf_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .ready     (ready),
        .enable    (enable),
        .inval_req (inval_req),
        .reg_rdata (reg_rdata)
    );

    icf_edge u_zedge (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_in  (zero_req),
        .pulse_out (zero_pulse)
    );

    icf_sweep #(
        .LINES      (LINES),
        .DATA_WORDS (DATA_WORDS),
        .TAG_W      (TAG_W),
        .DIDX_W     (DIDX_W),
        .ZLEN       (ZLEN),
        .IDX_W      (IDX_W)
    ) u_sweep (
        .clk         (clk),
        .rst_n       (rst_n),
        .inval_req   (inval_req),
        .zero_pulse  (zero_pulse),
        .ready       (ready),
        .tag_we      (tag_we),
        .tag_wr_zero (tag_wr_zero),
        .tag_idx     (tag_idx),
        .data_we     (data_we),
        .data_idx    (data_idx),
        .state       (seq_state),
        .idx         (seq_idx)
    );

    assign cache_use    = enable & ready;
    assign fetch_bypass = ~cache_use;

endmodule

// File: rtl/icache_flush_ctl_chk.sv
module icache_flush_ctl_chk
    import icf_pkg::*;
#(
    parameter int LINES      = 512,
    parameter int DATA_WORDS = 4096,
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int TAG_W      = $clog2(LINES),
    parameter int ZLEN       = (DATA_WORDS > LINES) ? DATA_WORDS : LINES,
    parameter int IDX_W      = $clog2(ZLEN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wdata0,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              cache_use,
    input logic              tag_we,
    input logic              tag_wr_zero,
    input logic [TAG_W-1:0]  tag_idx,
    input logic              data_we,
    input logic              ready,
    input logic              zero_pulse,
    input sweep_e            seq_state,
    input logic [IDX_W-1:0]  seq_idx
);

    // R2: reserved control bits always read back as zero
    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:READY_BIT+1] == '0 && reg_rdata[READY_BIT-1:1] == '0);

    // R3: a flush write outside zeroize starts invalidation at index 0
    assert_flush_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(FLUSH_OFF) && !zero_pulse && seq_state != SW_ZERO)
        |=> (tag_we && !tag_wr_zero && tag_idx == '0));

    // R4: clearing enable outside zeroize starts invalidation at index 0
    assert_disable_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(CTRL_OFF) && !reg_wdata0 && !zero_pulse &&
         seq_state != SW_ZERO)
        |=> (tag_we && !tag_wr_zero && tag_idx == '0));

    // R5: invalidation indices step by one unless restarting at zero
    assert_tag_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_we && !tag_wr_zero && $past(tag_we && !tag_wr_zero) && tag_idx != '0)
        |-> ((tag_idx - 1'b1) == $past(tag_idx)));

    // R5: ready rises only after the final index of an invalidation sweep
    assert_ready_after_inval_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready) && $past(seq_state) == SW_INVAL)
        |-> ($past(seq_idx) == IDX_W'(LINES - 1)));

    // R7: ready rises only after the final index of a zeroize sweep
    assert_ready_after_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready) && $past(seq_state) == SW_ZERO)
        |-> ($past(seq_idx) == IDX_W'(ZLEN - 1)));

    // R8: a zeroize edge always wins and starts at index zero
    assert_zero_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        zero_pulse |=> (seq_state == SW_ZERO && seq_idx == '0));

    // R9: no array write while fetches are served from the cache
    assert_no_write_in_use_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cache_use |-> (!tag_we && !data_we));

    // R7: data writes only happen while the cache is not ready
    assert_data_we_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_we |-> !ready);

endmodule

bind icache_flush_ctl icache_flush_ctl_chk #(
    .LINES      (LINES),
    .DATA_WORDS (DATA_WORDS),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .TAG_W      (TAG_W),
    .ZLEN       (ZLEN),
    .IDX_W      (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata0  (reg_wdata[0]),
    .reg_rdata   (reg_rdata),
    .cache_use   (cache_use),
    .tag_we      (tag_we),
    .tag_wr_zero (tag_wr_zero),
    .tag_idx     (tag_idx),
    .data_we     (data_we),
    .ready       (ready),
    .zero_pulse  (zero_pulse),
    .seq_state   (seq_state),
    .seq_idx     (seq_idx)
);

// File: tb/icache_flush_ctl_bench.sv
module icache_flush_ctl_bench;

    localparam int LINES = 8;
    localparam int WORDS = 16;
    localparam int ZLEN  = (WORDS > LINES) ? WORDS : LINES;
    localparam int TW    = $clog2(LINES);
    localparam int DW    = $clog2(WORDS);
    localparam logic [11:0] A_CTRL  = 12'h100;
    localparam logic [11:0] A_FLUSH = 12'h700;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          zero_req = 1'b0;
    logic          cache_use, fetch_bypass;
    logic          tag_we, tag_wr_zero, data_we;
    logic [TW-1:0] tag_idx;
    logic [DW-1:0] data_idx;

    always #5 clk = ~clk;

    icache_flush_ctl #(
        .LINES      (LINES),
        .DATA_WORDS (WORDS)
    ) u_icache_flush_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .zero_req     (zero_req),
        .cache_use    (cache_use),
        .fetch_bypass (fetch_bypass),
        .tag_we       (tag_we),
        .tag_wr_zero  (tag_wr_zero),
        .tag_idx      (tag_idx),
        .data_we      (data_we),
        .data_idx     (data_idx)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // port monitors, sampled on the falling edge
    int inv_cnt = 0, ztag_cnt = 0, zdata_cnt = 0, busy_cnt = 0, order_err = 0;
    logic [LINES-1:0] inv_mask = '0;
    logic [WORDS-1:0] zd_mask = '0;
    logic [TW-1:0]    prev_idx = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (tag_we && !tag_wr_zero) begin
                inv_cnt++;
                inv_mask[tag_idx] = 1'b1;
                if (tag_idx != '0 && tag_idx != prev_idx + 1'b1) order_err++;
                prev_idx = tag_idx;
            end
            if (tag_we && tag_wr_zero) ztag_cnt++;
            if (data_we) begin
                zdata_cnt++;
                zd_mask[data_idx] = 1'b1;
            end
            if (!cache_use) busy_cnt++;
        end
    end

    int b_inv, b_ztag, b_zdata, b_busy;

    task automatic snap();
        b_inv = inv_cnt; b_ztag = ztag_cnt; b_zdata = zdata_cnt; b_busy = busy_cnt;
        inv_mask = '0; zd_mask = '0;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic zero_pulse();
        zero_req = 1'b1;
        idle(1);
        zero_req = 1'b0;
    endtask

    logic [31:0] rd;
    logic [31:0] vals [4] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'hA5A5_5A5A};

    initial begin
        idle(3);
        check(reg_rdata == 32'h0, "R1", "rdata in reset", reg_rdata, 0);
        check(cache_use == 1'b0 && fetch_bypass == 1'b1, "R9", "bypass in reset",
              {cache_use, fetch_bypass}, 2'b01);
        rst_n = 1'b1;
        bus_read(A_CTRL, rd);
        check(rd == 32'h0, "R1", "ctrl during power-on sweep", rd, 32'h0);
        idle(LINES + 3);
        check(inv_cnt == LINES, "R1", "power-on tag clears", inv_cnt, LINES);
        check(inv_mask == '1 && order_err == 0, "R5", "power-on index coverage",
              inv_mask, {LINES{1'b1}});
        bus_read(A_CTRL, rd);
        check(rd == 32'h0001_0000, "R1", "ctrl after power-on", rd, 32'h0001_0000);

        // enable with all bits set: reserved ignored, no sweep
        snap();
        bus_write(A_CTRL, 32'hFFFF_FFFF);
        idle(3);
        check(inv_cnt - b_inv == 0, "R4", "no sweep on enable=1", inv_cnt - b_inv, 0);
        bus_read(A_CTRL, rd);
        check(rd == 32'h0001_0001, "R2", "ctrl reserved bits", rd, 32'h0001_0001);
        check(cache_use == 1'b1 && fetch_bypass == 1'b0, "R9", "cache in use",
              {cache_use, fetch_bypass}, 2'b10);
        bus_write(A_CTRL, 32'h0001_0001);
        bus_read(A_CTRL, rd);
        check(rd == 32'h0001_0001, "R2", "ready not writable", rd, 32'h0001_0001);

        // flush writes of several values
        foreach (vals[i]) begin
            snap();
            bus_write(A_FLUSH, vals[i]);
            bus_read(A_CTRL, rd);
            check(rd == 32'h0000_0001, "R3", "ready low after flush", rd, 32'h1);
            idle(LINES + 2);
            check(inv_cnt - b_inv == LINES, "R3", "flush tag clears", inv_cnt - b_inv, LINES);
            check(busy_cnt - b_busy == LINES, "R5", "flush busy cycles",
                  busy_cnt - b_busy, LINES);
            check(inv_mask == '1 && order_err == 0, "R5", "flush index coverage",
                  inv_mask, {LINES{1'b1}});
        end
        bus_read(A_FLUSH, rd);
        check(rd == 32'h0, "R3", "flush reg reads zero", rd, 0);
        bus_read(12'h234, rd);
        check(rd == 32'h0, "R3", "unmapped reads zero", rd, 0);

        // restart at every offset within an invalidation sweep
        for (int k = 1; k <= LINES; k++) begin
            snap();
            bus_write(A_FLUSH, 32'h0);
            idle(k - 1);
            bus_write(A_FLUSH, 32'h0);
            idle(LINES + 3);
            check(inv_cnt - b_inv == k + LINES, "R6", "restart tag clears",
                  inv_cnt - b_inv, k + LINES);
            check(busy_cnt - b_busy == k + LINES, "R6", "restart busy cycles",
                  busy_cnt - b_busy, k + LINES);
        end

        // clearing enable invalidates
        snap();
        bus_write(A_CTRL, 32'h0);
        idle(LINES + 2);
        check(inv_cnt - b_inv == LINES, "R4", "disable sweeps", inv_cnt - b_inv, LINES);
        bus_read(A_CTRL, rd);
        check(rd == 32'h0001_0000, "R4", "ctrl after disable", rd, 32'h0001_0000);
        check(cache_use == 1'b0, "R9", "disabled bypass", cache_use, 0);
        bus_write(A_CTRL, 32'h1);

        // zeroize
        snap();
        zero_pulse();
        idle(ZLEN + 3);
        check(ztag_cnt - b_ztag == LINES, "R7", "zeroize tag writes", ztag_cnt - b_ztag, LINES);
        check(zdata_cnt - b_zdata == WORDS, "R7", "zeroize data writes",
              zdata_cnt - b_zdata, WORDS);
        check(zd_mask == '1, "R7", "zeroize data coverage", zd_mask, {WORDS{1'b1}});
        check(busy_cnt - b_busy == ZLEN, "R7", "zeroize busy", busy_cnt - b_busy, ZLEN);
        check(inv_cnt - b_inv == 0, "R7", "zeroize no invalidation", inv_cnt - b_inv, 0);

        // held level: one sweep
        snap();
        zero_req = 1'b1;
        idle(3 * ZLEN);
        zero_req = 1'b0;
        idle(3);
        check(busy_cnt - b_busy == ZLEN, "R7", "held level one sweep", busy_cnt - b_busy, ZLEN);

        // second edge restarts zeroize
        snap();
        zero_pulse();
        idle(3);
        zero_pulse();
        idle(ZLEN + 3);
        check(busy_cnt - b_busy == 4 + ZLEN, "R7", "zeroize restart busy",
              busy_cnt - b_busy, 4 + ZLEN);
        check(zdata_cnt - b_zdata == 4 + WORDS, "R7", "zeroize restart data",
              zdata_cnt - b_zdata, 4 + WORDS);

        // same-cycle collision: zeroize wins
        snap();
        zero_req = 1'b1;
        bus_write(A_FLUSH, 32'h5);
        zero_req = 1'b0;
        idle(ZLEN + 3);
        check(inv_cnt - b_inv == 0, "R8", "collision no invalidation", inv_cnt - b_inv, 0);
        check(busy_cnt - b_busy == ZLEN, "R8", "collision busy", busy_cnt - b_busy, ZLEN);

        // flush during zeroize ignored
        snap();
        zero_pulse();
        idle(2);
        bus_write(A_FLUSH, 32'h0);
        idle(ZLEN + 3);
        check(inv_cnt - b_inv == 0, "R8", "flush in zeroize ignored", inv_cnt - b_inv, 0);
        check(busy_cnt - b_busy == ZLEN, "R8", "flush in zeroize busy", busy_cnt - b_busy, ZLEN);

        // zeroize preempts invalidation
        snap();
        bus_write(A_FLUSH, 32'h0);
        idle(2);
        zero_pulse();
        idle(ZLEN + 3);
        check(inv_cnt - b_inv == 3, "R8", "preempted invalidation", inv_cnt - b_inv, 3);
        check(busy_cnt - b_busy == 3 + ZLEN, "R8", "preempt busy", busy_cnt - b_busy, 3 + ZLEN);
        bus_read(A_CTRL, rd);
        check(rd == 32'h0001_0001, "R10", "ctrl read after all", rd, 32'h0001_0001);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule